// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a 32-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software sees a small set of word registers, each holding one bit per pin: an output latch, a per-pin direction control, a view of the sampled pin inputs, and two pull configuration words. The latch, direction and pull bits go straight to the pad ring as output values, output enables, pull enables and pull-type selects.

Beside the direct output register there are two alias addresses that act on the same latch. A write to the set alias turns on every latch bit where the write data has a 1. A write to the clear alias turns off every such bit. Other bits keep their values, so one agent can change a single pin without a read-modify-write race against another. Input pins cross into the bus clock through a two-flop synchronizer before they can be read. Read data is registered and shows up on the cycle after the read request.

Top module: `gpio_port_bank`

## Requirements
- R1: While reset is high and after it ends, `pin_out`, `pin_oe`, `pull_en` and `pull_sel` are all zero, so every pin starts as an input, and reads of offsets 0x00, 0x08, 0x18 and 0x1C return zero.
- R2: A write to offset 0x00 loads the whole output latch from `wr_data`. `pin_out` shows the new value on the cycle after the write, and a read of 0x00 returns it.
- R3: A write to offset 0x08 loads the direction word. Bit value 1 makes that pin an output. `pin_oe` equals the direction word, which reads back at 0x08.
- R4: A write to offset 0x10 sets every latch bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R5: A write to offset 0x14 clears every latch bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R6: Writes to offset 0x18 load the pull-enable word, driven on `pull_en`. Writes to 0x1C load the pull-type word, driven on `pull_sel`. Both read back at their offsets.
- R7: A read of offset 0x04 returns `pin_in` after two synchronizer flops. A value held steady on `pin_in` for two clock edges is returned by a read issued after those edges.
- R8: Reads of 0x10 and 0x14 return zero. Writes to 0x04 change no register and no output.
- R9: Reads of any offset not listed above, including unaligned ones, return zero, and writes to them change no register and no output.
- R10: `rd_data` carries the selected value on the cycle after a cycle with `rd_en` high, and is zero after any cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Output latch value to the pads |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| pull_en | output | 32 | Per-pin pull enable |
| pull_sel | output | 32 | Per-pin pull type select |

## Verification
The embedded properties assume the bus inputs are known (never X) outside reset, that at most one write lands per cycle, and that `pin_in` may change at any edge, so no property predicts input readback. The stimulus drives `addr`, `wr_en`, `rd_en` and `wr_data` only on falling edges, keeps every strobe one cycle wide, and holds `pin_in` steady for three edges before it reads the synchronized value. Set and clear patterns are chosen to overlap bits that are already set and bits that are already clear, so a merge that overwrites the latch shows up as a wrong value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Word offsets of the register bank
    localparam addr_t OFF_OUT   = 8'h00;
    localparam addr_t OFF_IN    = 8'h04;
    localparam addr_t OFF_DIR   = 8'h08;
    localparam addr_t OFF_SET   = 8'h10;
    localparam addr_t OFF_CLR   = 8'h14;
    localparam addr_t OFF_PEN   = 8'h18;
    localparam addr_t OFF_PTYPE = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_IN,
        SEL_DIR,
        SEL_SET,
        SEL_CLR,
        SEL_PEN,
        SEL_PTYPE
    } reg_sel_e;

    typedef struct packed {
        word_t dir;
        word_t pull_en;
        word_t pull_sel;
    } pad_cfg_t;

    function automatic reg_sel_e decode_offset(addr_t a);
        reg_sel_e s;
        case (a)
            OFF_OUT:   s = SEL_OUT;
            OFF_IN:    s = SEL_IN;
            OFF_DIR:   s = SEL_DIR;
            OFF_SET:   s = SEL_SET;
            OFF_CLR:   s = SEL_CLR;
            OFF_PEN:   s = SEL_PEN;
            OFF_PTYPE: s = SEL_PTYPE;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_bank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t d,
    output word_t q
);
    word_t chain [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  word_t    wdata,
    output word_t    out_q
);
    word_t out_n;

    always_comb begin
        out_n = out_q;
        if (wr_en) begin
            case (sel)
                SEL_OUT: out_n = wdata;
                SEL_SET: out_n = out_q | wdata;
                SEL_CLR: out_n = out_q & ~wdata;
                default: out_n = out_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_n;
    end

    // R4
    set_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SET) |=> ((out_q & $past(wdata)) == $past(wdata))
                                      && ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

    // R5
    clr_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CLR) |=> ((out_q & $past(wdata)) == '0)
                                      && ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel == SEL_OUT || sel == SEL_SET || sel == SEL_CLR)) |=> $stable(out_q));

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  word_t    wdata,
    output pad_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:   cfg.dir      <= wdata;
                SEL_PEN:   cfg.pull_en  <= wdata;
                SEL_PTYPE: cfg.pull_sel <= wdata;
                default: ;
            endcase
        end
    end

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_DIR) |=> $stable(cfg.dir));

    // R6
    pull_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel == SEL_PEN || sel == SEL_PTYPE))
        |=> ($stable(cfg.pull_en) && $stable(cfg.pull_sel)));

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pull_en,
    output logic [DATA_W-1:0] pull_sel
);
    reg_sel_e sel;
    word_t    out_q;
    word_t    in_sync;
    pad_cfg_t cfg;
    word_t    rd_mux;
    word_t    rd_q;

    assign sel = decode_offset(addr);

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    gpio_out_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wr_data),
        .out_q (out_q)
    );

    gpio_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wr_data),
        .cfg   (cfg)
    );

    always_comb begin
        case (sel)
            SEL_OUT:   rd_mux = out_q;
            SEL_IN:    rd_mux = in_sync;
            SEL_DIR:   rd_mux = cfg.dir;
            SEL_PEN:   rd_mux = cfg.pull_en;
            SEL_PTYPE: rd_mux = cfg.pull_sel;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
        else            rd_q <= '0;
    end

    assign rd_data  = rd_q;
    assign pin_out  = out_q;
    assign pin_oe   = cfg.dir;
    assign pull_en  = cfg.pull_en;
    assign pull_sel = cfg.pull_sel;

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    // R8
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == OFF_SET || addr == OFF_CLR)) |=> (rd_data == '0));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

    // R2
    out_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_OUT) |=> (rd_data == $past(pin_out)));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE)
        |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pull_en) && $stable(pull_sel)));

endmodule

// File: tb/gpio_port_bank_test.sv
`timescale 1ns/1ps
module gpio_port_bank_test;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pull_en, pull_sel;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;
    logic [31:0] model_out;

    always #5 clk = ~clk;

    gpio_port_bank uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pull_en(pull_en), .pull_sel(pull_sel)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compares each read result against the queued expectation
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: actual %08h expected <no pending read>", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1 pin_oe in reset", pin_oe, '0);
        check("R1 pin_out in reset", pin_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pull_en after reset", pull_en, '0);
        check("R1 pull_sel after reset", pull_sel, '0);
        bus_read(8'h00, '0, "R1 out read");
        bus_read(8'h08, '0, "R1 dir read");
        bus_read(8'h18, '0, "R1 pull_en read");
        bus_read(8'h1C, '0, "R1 pull_sel read");

        // R2 direct latch write
        model_out = 32'hA5A5_0F0F;
        bus_write(8'h00, model_out);
        check("R2 pin_out", pin_out, model_out);
        bus_read(8'h00, model_out, "R2 readback");

        // R4 set alias overlapping set and clear bits
        bus_write(8'h10, 32'h00FF_00F0);
        model_out = model_out | 32'h00FF_00F0;
        check("R4 pin_out after set", pin_out, model_out);
        bus_read(8'h00, model_out, "R4 readback");

        // R5 clear alias overlapping set and clear bits
        bus_write(8'h14, 32'hF000_0F3C);
        model_out = model_out & ~32'hF000_0F3C;
        check("R5 pin_out after clear", pin_out, model_out);
        bus_read(8'h00, model_out, "R5 readback");

        // R3 direction
        bus_write(8'h08, 32'h1234_5678);
        check("R3 pin_oe", pin_oe, 32'h1234_5678);
        bus_read(8'h08, 32'h1234_5678, "R3 readback");

        // R6 pull configuration
        bus_write(8'h18, 32'hCAFE_0001);
        bus_write(8'h1C, 32'h8000_FFFF);
        check("R6 pull_en", pull_en, 32'hCAFE_0001);
        check("R6 pull_sel", pull_sel, 32'h8000_FFFF);
        bus_read(8'h18, 32'hCAFE_0001, "R6 pull_en read");
        bus_read(8'h1C, 32'h8000_FFFF, "R6 pull_sel read");

        // R7 synchronized input, two patterns
        pin_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        bus_read(8'h04, 32'hDEAD_BEEF, "R7 input A");
        pin_in = 32'h0123_4567;
        repeat (3) @(negedge clk);
        bus_read(8'h04, 32'h0123_4567, "R7 input B");

        // R8 aliases read zero, write to input ignored
        bus_read(8'h10, '0, "R8 set alias read");
        bus_read(8'h14, '0, "R8 clear alias read");
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R8 pin_out after input write", pin_out, model_out);
        check("R8 pin_oe after input write", pin_oe, 32'h1234_5678);
        bus_read(8'h04, 32'h0123_4567, "R8 input after write");

        // R9 unmapped offsets
        bus_read(8'h0C, '0, "R9 read 0x0C");
        bus_read(8'h20, '0, "R9 read 0x20");
        bus_read(8'h01, '0, "R9 read unaligned");
        bus_write(8'h24, 32'hFFFF_FFFF);
        check("R9 pin_out after unmapped write", pin_out, model_out);
        check("R9 pull_en after unmapped write", pull_en, 32'hCAFE_0001);
        check("R9 pull_sel after unmapped write", pull_sel, 32'h8000_FFFF);

        // R10 idle cycle returns zero
        @(negedge clk);
        check("R10 idle rd_data", rd_data, '0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10: actual %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule